// File: doc/BRIEF.md
# Palette Memory with Five-Bit Channel Expansion

This block holds a table of 768 colour entries, each a 16-bit word, on a 16-bit processor bus. A bus write can update the whole word or one byte lane. A bus read returns the stored word. Each write also produces a 24-bit RGB value for the entry it wrote, built from the merged word.

A separate lookup port serves the video path. It takes a colour index and returns the expanded 8-bit red, green and blue values one clock later.

Each channel has five bits. The high four bits come from a nibble in the upper twelve bits of the word. The low bit comes from a shared field near the bottom of the word. Each 5-bit value is widened to eight bits by repeating its top three bits below it.

Top module: `pal_expand_ram`

## Requirements
- R1: After reset, `wr_rgb_valid` and `lk_valid` are low and `lk_rgb` is zero.
- R2: A write with both byte enables set stores `wr_data` at entry `addr`. The address is a word index from 0 to 767. A later read of that index returns the stored word on `rd_data` one cycle after `rd_en`.
- R3: A write with only `be[1]` set replaces bits 15:8 and keeps bits 7:0. A write with only `be[0]` set replaces bits 7:0 and keeps bits 15:8.
- R4: A write with `be` equal to 0 leaves the entry unchanged and does not pulse `wr_rgb_valid`.
- R5: Readback returns all 16 stored bits, including bit 0, which has no colour meaning.
- R6: The 5-bit channels are formed from a word w as follows:
  - red = {w[15:12], w[3]}
  - green = {w[11:8], w[2]}
  - blue = {w[7:4], w[1]}
- R7: A 5-bit channel c widens to 8 bits as {c, c[4:2]}. The 24-bit colour is packed as {red8, green8, blue8} from bit 23 down.
- R8: One cycle after an enabled write, `wr_rgb_valid` is high and `wr_rgb` is the colour of the merged word. `wr_idx` is the index that was written.
- R9: One cycle after `lk_en`, `lk_valid` is high and `lk_rgb` is the colour of entry `lk_idx`.
- R10: A lookup issued in the cycle after a write to the same entry returns the new colour. The same holds for a lookup issued in the same cycle as that write.
- R11: A write or lookup with an index of 768 or above is ignored. It stores nothing and raises no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 10 | Entry index for bus access |
| be | input | 2 | Byte enables: bit 1 selects the upper lane, bit 0 the lower lane |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid one cycle after `rd_en` |
| wr_rgb_valid | output | 1 | Pulse: a colour was updated |
| wr_idx | output | 10 | Index of the updated colour |
| wr_rgb | output | 24 | Expanded colour of the updated entry |
| lk_en | input | 1 | Lookup strobe |
| lk_idx | input | 10 | Lookup colour index |
| lk_valid | output | 1 | Lookup result valid |
| lk_rgb | output | 24 | Expanded colour of the looked-up entry |

## Verification
A lane-merge fault damages the stored word. Every later readback or lookup of that entry then shows the wrong value, one cycle after it is issued.

A wrong bit selection in the expansion shows up at once on `wr_rgb`, in the cycle after the write. A missing write-to-lookup forward shows a stale colour on `lk_rgb` only in the one cycle that follows a same-entry write. The bench therefore issues lookups back-to-back with writes. It compares every port against a behavioural table model on every clock.

// File: rtl/pal_expand_ram.sv
module pal_expand_ram #(
  parameter int ENTRIES = 768,
  parameter int AW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    be,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          wr_rgb_valid,
  output logic [AW-1:0] wr_idx,
  output logic [23:0]   wr_rgb,
  input  logic          lk_en,
  input  logic [AW-1:0] lk_idx,
  output logic          lk_valid,
  output logic [23:0]   lk_rgb
);

  function automatic logic [7:0] widen(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [23:0] expand(input logic [15:0] w);
    return {widen({w[15:12], w[3]}), widen({w[11:8], w[2]}), widen({w[7:4], w[1]})};
  endfunction

  logic [15:0] mem [ENTRIES];

  logic        wr_ok, lk_ok;
  logic [15:0] old_word, new_word;

  assign wr_ok    = wr_en && (be != 2'b00) && (int'(addr) < ENTRIES);
  assign lk_ok    = lk_en && (int'(lk_idx) < ENTRIES);
  assign old_word = (int'(addr) < ENTRIES) ? mem[addr] : 16'h0;
  assign new_word = {be[1] ? wr_data[15:8] : old_word[15:8],
                     be[0] ? wr_data[7:0]  : old_word[7:0]};

  always_ff @(posedge clk) begin
    if (wr_ok) mem[addr] <= new_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en && int'(addr) < ENTRIES) rd_data <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_rgb_valid <= 1'b0;
      wr_idx       <= '0;
      wr_rgb       <= '0;
      lk_valid     <= 1'b0;
      lk_rgb       <= '0;
    end else begin
      wr_rgb_valid <= wr_ok;
      if (wr_ok) begin
        wr_idx <= addr;
        wr_rgb <= expand(new_word);
      end
      lk_valid <= lk_ok;
      if (lk_ok)
        lk_rgb <= (wr_ok && addr == lk_idx) ? expand(new_word) : expand(mem[lk_idx]);
    end
  end

  p_wvalid_needs_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rgb_valid |-> ($past(be) != 2'b00));
  p_wvalid_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rgb_valid |-> (int'(wr_idx) < ENTRIES));
  p_lvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $past(lk_en));
  p_lk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_en) |-> $stable(lk_rgb));
  p_wr_replicate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rgb_valid |-> (wr_rgb[2:0] == wr_rgb[7:5] && wr_rgb[10:8] == wr_rgb[15:13]
                      && wr_rgb[18:16] == wr_rgb[23:21]));
  p_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && lk_ok && addr == lk_idx) |=> (lk_rgb == wr_rgb));
endmodule

// File: tb/pal_expand_ram_bench.sv
module pal_expand_ram_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, lk_en = 0;
  logic [9:0] addr = 0, lk_idx = 0, wr_idx;
  logic [1:0] be = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic wr_rgb_valid, lk_valid;
  logic [23:0] wr_rgb, lk_rgb;
  int tests = 0, fails = 0;

  pal_expand_ram u_pal_expand_ram (.*);

  always #5 clk = ~clk;

  logic [15:0] model [768];
  logic        e_wv = 0, e_lv = 0, e_rdv = 0;
  logic [9:0]  e_widx = 0;
  logic [23:0] e_wrgb = 0, e_lrgb = 0;
  logic [15:0] e_rd = 0;

  function automatic logic [23:0] col(input logic [15:0] w);
    logic [4:0] r, g, b;
    r = {w[15:12], w[3]}; g = {w[11:8], w[2]}; b = {w[7:4], w[1]};
    return {r, r[4:2], g, g[4:2], b, b[4:2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_wv <= 0; e_lv <= 0; e_rdv <= 0; e_wrgb <= 0; e_lrgb <= 0; e_widx <= 0;
    end else begin
      logic [15:0] nw;
      logic ok;
      ok = wr_en && be != 0 && addr < 768;
      nw = (addr < 768) ? model[addr] : 16'h0;
      if (be[1]) nw[15:8] = wr_data[15:8];
      if (be[0]) nw[7:0]  = wr_data[7:0];
      e_rdv <= rd_en && addr < 768;
      if (rd_en && addr < 768) e_rd <= model[addr];
      e_wv <= ok;
      if (ok) begin e_widx <= addr; e_wrgb <= col(nw); end
      e_lv <= lk_en && lk_idx < 768;
      if (lk_en && lk_idx < 768)
        e_lrgb <= (ok && addr == lk_idx) ? col(nw) : col(model[lk_idx]);
      if (ok) model[addr] = nw;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R8 wr_rgb_valid", wr_rgb_valid, e_wv);
    if (e_wv) begin
      chk("R6/R7/R8 wr_rgb", wr_rgb, e_wrgb);
      chk("R8 wr_idx", wr_idx, e_widx);
    end
    chk("R9/R11 lk_valid", lk_valid, e_lv);
    chk("R9/R10 lk_rgb", lk_rgb, e_lrgb);
    if (e_rdv) chk("R2/R3/R5 rd_data", rd_data, e_rd);
  end

  task automatic wr(input int a, input logic [1:0] b, input logic [15:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a[9:0]; be = b; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic rd(input int a);
    @(posedge clk); #1 rd_en = 1; addr = a[9:0];
    @(posedge clk); #1 rd_en = 0;
  endtask
  task automatic lk(input int a);
    @(posedge clk); #1 lk_en = 1; lk_idx = a[9:0];
    @(posedge clk); #1 lk_en = 0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 768; i++) model[i] = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 wr_rgb_valid", wr_rgb_valid, 0);
    chk("R1 lk_valid", lk_valid, 0);
    chk("R1 lk_rgb", lk_rgb, 0);
    rst_n = 1;
    for (int i = 0; i < 768; i++) wr(i, 2'b11, 16'h0);
    wr(5, 2'b11, 16'hF00E); rd(5); lk(5);
    wr(6, 2'b11, 16'h0F0D); rd(6); lk(6);
    wr(7, 2'b11, 16'h00F3); lk(7);
    wr(8, 2'b11, 16'hA5C1); rd(8);
    wr(8, 2'b10, 16'h3C00); rd(8);
    wr(8, 2'b01, 16'h0077); rd(8); lk(8);
    wr(8, 2'b00, 16'hFFFF); rd(8); lk(8);
    wr(767, 2'b11, 16'h8421); lk(767); rd(767);
    wr(768, 2'b11, 16'hFFFF); lk(768); wr(1000, 2'b11, 16'h1234); rd(0);
    @(posedge clk); #1 wr_en = 1; addr = 9; be = 2'b11; wr_data = 16'h6B5A;
    @(posedge clk); #1 wr_en = 0; lk_en = 1; lk_idx = 9;
    @(posedge clk); #1 lk_en = 0;
    @(posedge clk); #1 wr_en = 1; addr = 10; be = 2'b01; wr_data = 16'h00FF;
    lk_en = 1; lk_idx = 10;
    @(posedge clk); #1 wr_en = 0; lk_en = 0;
    for (int k = 0; k < 200; k++) begin
      int a;
      a = (k * 37) % 800;
      @(posedge clk); #1
      wr_en = k[0]; rd_en = k[1]; lk_en = 1;
      addr = a[9:0]; lk_idx = ((k % 3 == 0) ? a[9:0] : 10'((k * 11) % 780));
      be = k[3:2]; wr_data = 16'(k * 16'h9E37);
    end
    @(posedge clk); #1 wr_en = 0; rd_en = 0; lk_en = 0;
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule